// File: doc/BRIEF.md
# Overmodulation Track and Mode Selector

This block decides, once per switching period, which trajectory a multilevel space-vector modulator follows. It takes the modulation index (normalised so that six-step operation equals 1.0) and the reference angle measured inside the current 60-degree sector. It also takes two boundary angles that a host computes for the present index and loads as register values: the angle at which the reference meets the hexagon edge, and the hold angle. From these it produces a track index (circular, hexagonal or hold), a bit that picks which of the sector's two large vertices is held, and a mode code that names the index band.

The index is split into three bands. Below 0.907 the modulator is linear and always circular. From 0.907 up to 0.9535 is overmodulation I. In this band a window centred in the sector, bounded by the crossing angle and its mirror, rides the hexagon edge, and the remainder stays circular. From 0.9535 upward is overmodulation II. Its centred window is bounded by the hold angle and rides the hexagon edge, and the two outer parts of the sector freeze on a large vertex. At an index of 1.0 or more the hexagonal window disappears and only the six large vertices are used.

All outputs are registered. They change only on a clock edge on which the period-start strobe is high, and they hold for the rest of the period.

Top module: `omx_track_select`

## Requirements
- R1: While reset is asserted, and after it, until the first strobed edge, trackIdx is 0, modeCode is 0 and holdVertex is 0.
- R2: An index below 29721 (Q1.15, about 0.907) gives modeCode 0 (linear) and trackIdx 0 (circular) at every angle.
- R3: An index from 29721 to 31243 gives modeCode 1. The track is 1 (hexagonal) when crossAngle <= sectorAngle < 65536 - crossAngle, and 0 (circular) otherwise. The angles are 16-bit, and 65536 stands for 60 degrees.
- R4: An index from 31244 (about 0.9535) to 32767 gives modeCode 2. The track is 1 when holdAngle <= sectorAngle < 65536 - holdAngle, and 2 (hold) otherwise.
- R5: An index of 32768 (1.0) or more gives modeCode 2 and trackIdx 2 at every angle, whatever holdAngle is.
- R6: When trackIdx is 2, holdVertex is 0 (leading large vertex) for sectorAngle below 32768 and 1 (trailing large vertex) from 32768 up. When trackIdx is not 2, holdVertex is 0.
- R7: Outputs change only on a rising clock edge with periodStart high. Input changes without the strobe leave all outputs unchanged.
- R8: The band limits are inclusive at the lower edge: exactly 29721 is overmodulation I and exactly 31244 is overmodulation II.
- R9: trackIdx never takes the value 3, and modeCode never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodStart | input | 1 | Switching-period start strobe; outputs load on this edge |
| modIndex | input | 16 | Modulation index, unsigned Q1.15 (32768 = six-step) |
| sectorAngle | input | 16 | Angle inside the sector, 65536 = 60 degrees |
| crossAngle | input | 16 | Hexagon crossing angle for overmodulation I, same scale |
| holdAngle | input | 16 | Hold angle for overmodulation II, same scale |
| trackIdx | output | 2 | 0 circular, 1 hexagonal, 2 hold |
| holdVertex | output | 1 | Held large vertex: 0 leading, 1 trailing |
| modeCode | output | 2 | 0 linear, 1 overmodulation I, 2 overmodulation II |

## Verification
The band decision and the angle-window decision are made in the same strobed cycle. A change of index across a band limit therefore also switches which boundary angle bounds the window and what the outside of the window means.

The bench provokes this in several ways:
- It steps the index across 29721 and 31244 while placing the angle exactly on crossAngle, holdAngle or their mirrors.
- It sets crossAngle and holdAngle to different values, so that taking the wrong boundary in the new band gives a visibly wrong track.
- It makes random changes of index, angle and boundaries between strobes, to show that nothing moves without a strobe.

Each result is judged against a bench model of the bands and windows.

// File: rtl/omx_pkg.sv
package omx_pkg;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_OVM1   = 2'd1,
    MODE_OVM2   = 2'd2
  } modeCode_e;

  typedef enum logic [1:0] {
    TRK_CIRC = 2'd0,
    TRK_HEX  = 2'd1,
    TRK_HOLD = 2'd2
  } track_e;

  // strobes from band control to the window datapath
  typedef struct packed {
    logic load;      // capture a new decision this edge
    logic windowOn;  // a centred hexagonal window exists in this band
    logic ovm2;      // window bounded by hold angle, outside is hold
    logic sixStep;   // index at or above unity: hold everywhere
  } dpCtrl_t;

endpackage

// File: rtl/omx_band_ctrl.sv
module omx_band_ctrl
  import omx_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int LIN_LIMIT  = 29721,
  parameter int OVM2_LIMIT = 31244,
  parameter int UNITY      = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  input  logic [IDX_W-1:0] modIndex,
  output dpCtrl_t          ctrl,
  output modeCode_e        modeQ
);

  localparam logic [IDX_W-1:0] LinLim  = IDX_W'(LIN_LIMIT);
  localparam logic [IDX_W-1:0] Ovm2Lim = IDX_W'(OVM2_LIMIT);
  localparam logic [IDX_W-1:0] UnityV  = IDX_W'(UNITY);

  modeCode_e bandNext;
  logic      sixStepNow;

  always_comb begin
    if (modIndex < LinLim)       bandNext = MODE_LINEAR;
    else if (modIndex < Ovm2Lim) bandNext = MODE_OVM1;
    else                         bandNext = MODE_OVM2;
  end

  assign sixStepNow = (modIndex >= UnityV);

  always_comb begin
    ctrl.load     = periodStart;
    ctrl.windowOn = (bandNext != MODE_LINEAR) && !sixStepNow;
    ctrl.ovm2     = (bandNext == MODE_OVM2);
    ctrl.sixStep  = sixStepNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            modeQ <= MODE_LINEAR;
    else if (periodStart) modeQ <= bandNext;
  end

endmodule

// File: rtl/omx_window_dp.sv
module omx_window_dp
  import omx_pkg::*;
#(
  parameter int ANG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [ANG_W-1:0] sectorAngle,
  input  logic [ANG_W-1:0] crossAngle,
  input  logic [ANG_W-1:0] holdAngle,
  output track_e           trackQ,
  output logic             vertexQ
);

  localparam logic [ANG_W:0] SectorSpan = {1'b1, {ANG_W{1'b0}}};

  logic [ANG_W-1:0] lowerBound;
  logic [ANG_W:0]   upperBound;
  logic             inWindow;
  track_e           trackNext;
  logic             vertexNext;

  assign lowerBound = ctrl.ovm2 ? holdAngle : crossAngle;
  assign upperBound = SectorSpan - {1'b0, lowerBound};
  assign inWindow   = ctrl.windowOn && (sectorAngle >= lowerBound)
                      && ({1'b0, sectorAngle} < upperBound);

  always_comb begin
    if (ctrl.sixStep)   trackNext = TRK_HOLD;
    else if (inWindow)  trackNext = TRK_HEX;
    else if (ctrl.ovm2) trackNext = TRK_HOLD;
    else                trackNext = TRK_CIRC;
  end

  assign vertexNext = (trackNext == TRK_HOLD) && sectorAngle[ANG_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trackQ  <= TRK_CIRC;
      vertexQ <= 1'b0;
    end else if (ctrl.load) begin
      trackQ  <= trackNext;
      vertexQ <= vertexNext;
    end
  end

endmodule

// File: rtl/omx_track_select.sv
module omx_track_select
  import omx_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int ANG_W      = 16,
  parameter int LIN_LIMIT  = 29721,
  parameter int OVM2_LIMIT = 31244,
  parameter int UNITY      = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  input  logic [IDX_W-1:0] modIndex,
  input  logic [ANG_W-1:0] sectorAngle,
  input  logic [ANG_W-1:0] crossAngle,
  input  logic [ANG_W-1:0] holdAngle,
  output logic [1:0]       trackIdx,
  output logic             holdVertex,
  output logic [1:0]       modeCode
);

  dpCtrl_t   ctrl;
  modeCode_e modeQ;
  track_e    trackQ;

  omx_band_ctrl #(
    .IDX_W(IDX_W), .LIN_LIMIT(LIN_LIMIT),
    .OVM2_LIMIT(OVM2_LIMIT), .UNITY(UNITY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .periodStart(periodStart),
    .modIndex(modIndex), .ctrl(ctrl), .modeQ(modeQ)
  );

  omx_window_dp #(.ANG_W(ANG_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .sectorAngle(sectorAngle), .crossAngle(crossAngle), .holdAngle(holdAngle),
    .trackQ(trackQ), .vertexQ(holdVertex)
  );

  assign trackIdx = trackQ;
  assign modeCode = modeQ;

endmodule

// File: rtl/omx_track_select_chk.sv
module omx_track_select_chk #(
  parameter int IDX_W      = 16,
  parameter int LIN_LIMIT  = 29721,
  parameter int UNITY      = 32768
) (
  input logic             clk,
  input logic             rstN,
  input logic             periodStart,
  input logic [IDX_W-1:0] modIndex,
  input logic [1:0]       trackIdx,
  input logic             holdVertex,
  input logic [1:0]       modeCode
);

  AST_TRACK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (trackIdx != 2'd3) && (modeCode != 2'd3));  // R9

  AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(periodStart) |-> ($stable(trackIdx) && $stable(modeCode)
                             && $stable(holdVertex)));  // R7

  AST_LINEAR_CIRCULAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(periodStart) && ($past(modIndex) < IDX_W'(LIN_LIMIT)))
      |-> (trackIdx == 2'd0 && modeCode == 2'd0));  // R2

  AST_SIXSTEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(periodStart) && ($past(modIndex) >= IDX_W'(UNITY)))
      |-> (trackIdx == 2'd2 && modeCode == 2'd2));  // R5

  AST_VERTEX_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (trackIdx != 2'd2) |-> !holdVertex);  // R6

  AST_MODE_TRACK_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'd2) |-> (trackIdx != 2'd0));  // R4

endmodule

bind omx_track_select omx_track_select_chk #(
  .IDX_W(IDX_W), .LIN_LIMIT(LIN_LIMIT), .UNITY(UNITY)
) u_chk (.*);

// File: tb/omx_track_select_tb.sv
module omx_track_select_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        periodStart = 1'b0;
  logic [15:0] modIndex = '0;
  logic [15:0] sectorAngle = '0;
  logic [15:0] crossAngle = '0;
  logic [15:0] holdAngle = '0;
  logic [1:0]  trackIdx;
  logic        holdVertex;
  logic [1:0]  modeCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omx_track_select u_dut (.*);

  function automatic int expMode(int idx);
    if (idx < 29721) return 0;
    if (idx < 31244) return 1;
    return 2;
  endfunction

  function automatic int expTrack(int idx, int ang, int cr, int hd);
    int m = expMode(idx);
    if (m == 0) return 0;
    if (idx >= 32768) return 2;
    if (m == 1) return (ang >= cr && ang < 65536 - cr) ? 1 : 0;
    return (ang >= hd && ang < 65536 - hd) ? 1 : 2;
  endfunction

  function automatic int expVertex(int idx, int ang, int cr, int hd);
    return (expTrack(idx, ang, cr, hd) == 2 && ang >= 32768) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (idx=%0d ang=%0d cr=%0d hd=%0d)",
               req, act, exp, modIndex, sectorAngle, crossAngle, holdAngle);
    end
  endtask

  // drive at negedge, strobe one edge, sample at next negedge
  task automatic period(int idx, int ang, int cr, int hd, string req);
    @(negedge clk);
    modIndex = 16'(idx); sectorAngle = 16'(ang);
    crossAngle = 16'(cr); holdAngle = 16'(hd);
    periodStart = 1'b1;
    @(negedge clk);
    periodStart = 1'b0;
    check({req, " mode"},   int'(modeCode),   expMode(idx));
    check({req, " track"},  int'(trackIdx),   expTrack(idx, ang, cr, hd));
    check({req, " vertex"}, int'(holdVertex), expVertex(idx, ang, cr, hd));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int idxs[4] = '{29491, 30802, 32113, 32768};
    int seed;
    seed = $urandom(32'd1234);
    // R1: reset state, with inputs that would give nonzero outputs
    modIndex = 16'd32768; sectorAngle = 16'd60000;
    repeat (3) @(negedge clk);
    check("R1 track", int'(trackIdx), 0);
    check("R1 mode", int'(modeCode), 0);
    check("R1 vertex", int'(holdVertex), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(trackIdx), 0);

    // sweeps over the sector at four indices (R2..R6)
    foreach (idxs[k]) begin
      for (int a = 0; a < 65536; a += 1024) begin
        period(idxs[k], a, 9000, 14000, "R3R4R5R6 sweep");
      end
      period(idxs[k], 65535, 9000, 14000, "R6 sweep end");
    end

    // R2 linear at extreme angles
    period(0, 0, 5000, 5000, "R2 zero");
    period(29720, 32768, 0, 0, "R2 top");
    // R8 exact band limits with angle on boundaries, differing bounds
    period(29721, 9000, 9000, 20000, "R8 R3 lower edge");
    period(29721, 65536 - 9000, 9000, 20000, "R8 R3 mirror");
    period(29721, 65536 - 9001, 9000, 20000, "R3 inside mirror");
    period(31243, 8999, 9000, 20000, "R3 below cross");
    period(31244, 20000, 9000, 20000, "R8 R4 lower edge");
    period(31244, 19999, 9000, 20000, "R4 below hold");
    period(31244, 65536 - 20000, 9000, 20000, "R4 mirror");
    period(32767, 32768, 9000, 0, "R4 full window");
    // R5 unity and above, window would be full
    period(32768, 32768, 0, 0, "R5 unity");
    period(65535, 100, 0, 0, "R5 above");
    // R6 vertex split
    period(32768, 32767, 0, 0, "R6 leading");
    period(32768, 32768, 0, 0, "R6 trailing");
    period(32000, 40000, 0, 40000, "R6 hold with empty window");

    // R7: inputs move without strobe
    period(32768, 60000, 0, 0, "R7 setup");
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      modIndex = 16'($urandom_range(0, 29000));
      sectorAngle = 16'($urandom_range(0, 65535));
      @(negedge clk);
      check("R7 track", int'(trackIdx), 2);
      check("R7 mode", int'(modeCode), 2);
      check("R7 vertex", int'(holdVertex), 1);
    end

    // random mixes (R2..R6, R9)
    for (int n = 0; n < 600; n++) begin
      int idx = (n % 3 == 0) ? int'($urandom_range(28000, 34000))
                             : int'($urandom_range(0, 65535));
      int cr = int'($urandom_range(0, 36000));
      int hd = int'($urandom_range(0, 36000));
      int ang = int'($urandom_range(0, 65535));
      period(idx, ang, cr, hd, "R9 random");
      checks++;
      if (trackIdx == 2'd3 || modeCode == 2'd3) begin
        errors++;
        $display("FAIL R9 actual=%0d/%0d expected=not 3", trackIdx, modeCode);
      end
    end

    finish_run();
  end

endmodule